// File: doc/BRIEF.md
# USB Transmit Framer and Line Encoder

This block is the transmit half of a USB physical-layer data path. A link controller hands it bytes through a valid/ready handshake. Packet boundaries come only from the transmit-valid level. A rising edge opens a packet. The block then sends a synchronisation byte, every accepted byte least significant bit first, and the end-of-packet symbols once valid has fallen and the loaded bytes have gone out.

Between the byte handshake and the line, the block inserts a zero after any run of six ones. It then NRZI-encodes the stream. The result is a line symbol per bit-time: a data level, a single-ended-zero flag and an output enable. Bit-times are marked by a clock-enable input, so one core clock can serve any bit rate at or below its own.

A two-bit operating mode selects between three behaviours:
- normal line coding;
- a non-driving mode that still consumes the packet;
- a raw test mode with neither stuffing nor NRZI.

The mode is captured when a packet starts.

Top module: `usb_tx_framer`

## Requirements
- R1: While reset is held and after its release, with no packet started, `tx_ready_o` is 0, `line_oe_o` is 0, `line_se0_o` is 0 and `line_dat_o` is 1 (idle J).
- R2: For the first 5 clock edges after reset release, `tx_valid_i` is ignored. A valid raised in that window and held high starts no packet: no ready and no output enable.
- R3: A rising edge of `tx_valid_i` while idle starts a packet. The first eight driven bit-times carry the pattern 0x80 sent least significant bit first.
- R4: `tx_ready_o` high in a cycle means the byte on `tx_data_i` is taken at that clock edge. Taken bytes are sent in order, LSB first. `tx_ready_o` is never high while `tx_valid_i` is low.
- R5: In modes 0 and 3, a 0 is inserted after every six consecutive 1s of the unencoded stream. This includes the synchronisation byte, runs that cross byte boundaries, and a run that ends the last byte; in the last case the inserted 0 comes before the end-of-packet symbols.
- R6: NRZI encoding: a 0 toggles `line_dat_o`, a 1 keeps it. Each packet starts from level 1 (J).
- R7: After `tx_valid_i` falls and all taken bytes are sent, the line carries two bit-times of `line_se0_o`=1 with `line_dat_o`=0. It then carries one driven bit-time of `line_dat_o`=1, `line_se0_o`=0. `line_oe_o` then returns to 0.
- R8: Mode 1 (non-driving): the packet is framed and its bytes are taken through the handshake, but `line_oe_o` stays 0 throughout.
- R9: Mode 2 (raw): each bit-time carries the unencoded bit, with no inserted zeros. The synchronisation byte and the end-of-packet symbols are still sent.
- R10: Mode 3 produces exactly the same line symbols as mode 0.
- R11: `mode_i` is captured at packet start. A change during a packet takes effect only for a later packet.
- R12: The three line outputs change only at a clock edge where `bit_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle strobe marking each bit-time |
| mode_i | input | 2 | 0 normal, 1 non-driving, 2 raw, 3 as normal |
| tx_valid_i | input | 1 | Packet in progress; edges frame the packet |
| tx_data_i | input | DATA_W | Byte presented by the link controller |
| tx_ready_o | output | 1 | Byte taken at this clock edge |
| line_dat_o | output | 1 | Line data level (1 = J) |
| line_se0_o | output | 1 | Single-ended-zero symbol flag |
| line_oe_o | output | 1 | Line driver enable |

## Verification
Two events can fall on the same bit-time: a stuffed zero, and either the end of a byte or the start of end-of-packet. In that case the stuffed bit must come first, and it postpones the hold-register hand-off by one bit-time. Packets of 0xFF bytes drive a run of ones across a byte boundary. A final byte of 0xFC ends the packet on a sixth one. A scoreboard predicts every driven symbol from the requirements and compares it in order, so a stuffed bit that is misplaced, missing or duplicated shifts all later symbols and is reported.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

  typedef enum logic [1:0] {
    OPM_NORMAL  = 2'd0,
    OPM_NODRIVE = 2'd1,
    OPM_RAW     = 2'd2,
    OPM_RSVD    = 2'd3
  } opmode_e;

  typedef enum logic [1:0] {
    SYM_IDLE,
    SYM_BIT,
    SYM_SE0,
    SYM_J
  } sym_kind_e;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_DATA,
    FR_END,
    FR_SE0B,
    FR_JST
  } fr_state_e;

  typedef struct packed {
    sym_kind_e kind;
    logic      bit_v;
    logic      raw;
    logic      drive;
  } sym_t;

endpackage

// File: rtl/usb_tx_start_gate.sv
module usb_tx_start_gate #(
  parameter int GUARD_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_valid_i,
  output logic start_o
);
  localparam int CW = $clog2(GUARD_CYC + 2);

  logic [CW-1:0] cnt_q;
  logic          vld_q;
  logic          done;

  assign done    = (cnt_q == CW'(GUARD_CYC));
  assign start_o = done && tx_valid_i && !vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= tx_valid_i;
      if (!done) cnt_q <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/usb_tx_hold.sv
module usb_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              accept_en_i,
  input  logic              take_i,
  output logic              tx_ready_o,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign tx_ready_o = tx_valid_i && accept_en_i && !full_q;
  assign full_o     = full_q;
  assign data_o     = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (tx_ready_o) begin
      data_q <= tx_data_i;
      full_q <= 1'b1;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assert_take_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q);

  assert_hold_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !take_i) |=> (full_q && $stable(data_q)));

endmodule

// File: rtl/usb_tx_serial.sv
module usb_tx_serial
  import usb_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  output logic              take_o,
  output logic              accept_en_o,
  output sym_t              sym_o
);
  localparam int BCW = $clog2(DATA_W);
  localparam int OCW = $clog2(STUFF_RUN + 1);
  localparam logic [DATA_W-1:0] SYNC_PAT = {1'b1, {(DATA_W-1){1'b0}}};

  fr_state_e         state_q;
  opmode_e           mode_q;
  logic [DATA_W-1:0] sr_q;
  logic [BCW-1:0]    bcnt_q;
  logic [OCW-1:0]    ones_q;

  logic stuff_en, stuff_now, last_bit;

  assign stuff_en    = (mode_q != OPM_RAW);
  assign stuff_now   = stuff_en && (ones_q == OCW'(STUFF_RUN));
  assign last_bit    = (bcnt_q == BCW'(DATA_W - 1));
  assign accept_en_o = (state_q == FR_DATA);
  assign take_o      = bit_en_i && (state_q == FR_DATA) && !stuff_now && last_bit && hold_full_i;

  always_comb begin
    sym_o.kind  = SYM_IDLE;
    sym_o.bit_v = 1'b0;
    sym_o.raw   = (mode_q == OPM_RAW);
    sym_o.drive = (mode_q != OPM_NODRIVE);
    case (state_q)
      FR_DATA: begin
        sym_o.kind  = SYM_BIT;
        sym_o.bit_v = stuff_now ? 1'b0 : sr_q[0];
      end
      FR_END:  sym_o.kind = stuff_now ? SYM_BIT : SYM_SE0;
      FR_SE0B: sym_o.kind = SYM_SE0;
      FR_JST:  sym_o.kind = SYM_J;
      default: sym_o.kind = SYM_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FR_IDLE;
      mode_q  <= OPM_NORMAL;
      sr_q    <= '0;
      bcnt_q  <= '0;
      ones_q  <= '0;
    end else if (state_q == FR_IDLE) begin
      if (start_i) begin
        state_q <= FR_DATA;
        mode_q  <= opmode_e'(mode_i);
        sr_q    <= SYNC_PAT;
        bcnt_q  <= '0;
        ones_q  <= '0;
      end
    end else if (bit_en_i) begin
      case (state_q)
        FR_DATA: begin
          if (stuff_now) begin
            ones_q <= '0;
          end else begin
            ones_q <= (sr_q[0] && stuff_en) ? ones_q + OCW'(1) : '0;
            if (last_bit) begin
              if (hold_full_i) begin
                sr_q   <= hold_data_i;
                bcnt_q <= '0;
              end else begin
                state_q <= FR_END;
              end
            end else begin
              sr_q   <= sr_q >> 1;
              bcnt_q <= bcnt_q + BCW'(1);
            end
          end
        end
        FR_END: begin
          if (stuff_now) ones_q <= '0;
          else           state_q <= FR_SE0B;
        end
        FR_SE0B: state_q <= FR_JST;
        default: state_q <= FR_IDLE;
      endcase
    end
  end

  // a stuffed bit must not advance the byte
  assert_stuff_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && state_q == FR_DATA && stuff_now) |=> ($stable(sr_q) && $stable(bcnt_q)));

  assert_mode_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != FR_IDLE) |=> $stable(mode_q));

endmodule

// File: rtl/usb_tx_line.sv
module usb_tx_line
  import usb_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  sym_t sym_i,
  output logic line_dat_o,
  output logic line_se0_o,
  output logic line_oe_o
);
  logic dat_q, se0_q, oe_q;

  assign line_dat_o = dat_q;
  assign line_se0_o = se0_q;
  assign line_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= 1'b1;
      se0_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (bit_en_i) begin
      case (sym_i.kind)
        SYM_BIT: begin
          se0_q <= 1'b0;
          oe_q  <= sym_i.drive;
          if (sym_i.raw) dat_q <= sym_i.bit_v;
          else if (!sym_i.bit_v) dat_q <= ~dat_q;
        end
        SYM_SE0: begin
          dat_q <= 1'b0;
          se0_q <= 1'b1;
          oe_q  <= sym_i.drive;
        end
        SYM_J: begin
          dat_q <= 1'b1;
          se0_q <= 1'b0;
          oe_q  <= sym_i.drive;
        end
        default: begin
          dat_q <= 1'b1;
          se0_q <= 1'b0;
          oe_q  <= 1'b0;
        end
      endcase
    end
  end

  assert_line_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable({dat_q, se0_q, oe_q}));

  assert_se0_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    se0_q |-> !dat_q);

  assert_nodrive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !sym_i.drive) |=> !oe_q);

endmodule

// File: rtl/usb_tx_framer.sv
module usb_tx_framer
  import usb_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6,
  parameter int GUARD_CYC = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic [1:0]        mode_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              line_dat_o,
  output logic              line_se0_o,
  output logic              line_oe_o
);
  logic              start, take, accept_en, hold_full;
  logic [DATA_W-1:0] hold_data;
  sym_t              sym;

  usb_tx_start_gate #(.GUARD_CYC(GUARD_CYC)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_valid_i (tx_valid_i),
    .start_o    (start)
  );

  usb_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_valid_i  (tx_valid_i),
    .tx_data_i   (tx_data_i),
    .accept_en_i (accept_en),
    .take_i      (take),
    .tx_ready_o  (tx_ready_o),
    .full_o      (hold_full),
    .data_o      (hold_data)
  );

  usb_tx_serial #(.DATA_W(DATA_W), .STUFF_RUN(STUFF_RUN)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .start_i     (start),
    .mode_i      (mode_i),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .take_o      (take),
    .accept_en_o (accept_en),
    .sym_o       (sym)
  );

  usb_tx_line u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .sym_i      (sym),
    .line_dat_o (line_dat_o),
    .line_se0_o (line_se0_o),
    .line_oe_o  (line_oe_o)
  );

endmodule

// File: tb/tb_usb_tx_framer.sv
module tb_usb_tx_framer;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en = 1'b0;
  logic       tx_valid = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] tx_data = 8'h00;
  logic       ready, dat, se0, oe;

  always #4 clk = ~clk;

  usb_tx_framer dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .mode_i(mode),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(ready),
    .line_dat_o(dat), .line_se0_o(se0), .line_oe_o(oe)
  );

  int         total = 0;
  int         bad = 0;
  int         div_cnt = 0;
  int         sym_idx = 0;
  logic       mon_on = 1'b0;
  logic [2:0] prev_out = 3'b000;
  logic [1:0] exp_q[$];
  string      cur_req = "R1";

  // monitor: pops expected {se0,dat} per driven bit-time
  always @(negedge clk) begin
    if (mon_on) begin
      if (bit_en) begin
        if (oe) begin
          total++;
          if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL %s symbol %0d: got se0/dat=%b%b expected no driven symbol", cur_req, sym_idx, se0, dat);
          end else begin
            automatic logic [1:0] e = exp_q.pop_front();
            if ({se0, dat} !== e) begin
              bad++;
              $display("FAIL %s symbol %0d: got se0/dat=%b%b expected %b", cur_req, sym_idx, se0, dat, e);
            end
          end
          sym_idx++;
        end
      end else begin
        total++;
        if ({dat, se0, oe} !== prev_out) begin
          bad++;
          $display("FAIL R12 outputs moved without bit enable: got %b expected %b", {dat, se0, oe}, prev_out);
        end
      end
      if (!tx_valid && ready) begin
        total++; bad++;
        $display("FAIL R4 ready while valid low: got 1 expected 0");
      end
    end
    prev_out = {dat, se0, oe};
    div_cnt  = (div_cnt + 1) % DIV;
    bit_en   = (div_cnt == 0);
  end

  function automatic void put_bit(logic x, bit raw, ref logic lvl);
    if (raw) exp_q.push_back({1'b0, x});
    else begin
      if (!x) lvl = ~lvl;
      exp_q.push_back({1'b0, lvl});
    end
  endfunction

  function automatic void build(logic [7:0] b[$], logic [1:0] m);
    bit   raw = (m == 2'd2);
    logic lvl = 1'b1;
    int   ones = 0;
    logic [7:0] all[$];
    if (m == 2'd1) return;
    all = b;
    all.push_front(8'h80);
    foreach (all[i]) begin
      for (int k = 0; k < 8; k++) begin
        put_bit(all[i][k], raw, lvl);
        if (!raw) begin
          ones = all[i][k] ? ones + 1 : 0;
          if (ones == 6) begin
            put_bit(1'b0, raw, lvl);
            ones = 0;
          end
        end
      end
    end
    exp_q.push_back(2'b10);
    exp_q.push_back(2'b10);
    exp_q.push_back(2'b01);
  endfunction

  task automatic send(input logic [7:0] b[$], input logic [1:0] m, input logic [1:0] m_mid, input string req);
    int n = b.size();
    cur_req = req;
    sym_idx = 0;
    build(b, m);
    @(negedge clk); mode = m;
    @(negedge clk); tx_valid = 1'b1; tx_data = (n > 0) ? b[0] : 8'h00;
    @(negedge clk); mode = m_mid;
    for (int i = 0; i < n; i++) begin
      int t = 0;
      while (!ready && t < 2000) begin @(negedge clk); t++; end
      total++;
      if (!ready) begin
        bad++;
        $display("FAIL %s byte %0d not taken: got ready=0 expected 1", req, i);
      end
      @(negedge clk);
      if (i + 1 < n) tx_data = b[i + 1];
    end
    tx_valid = 1'b0;
    repeat ((n + 4) * 12 * DIV) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL %s symbols missing: got %0d left expected 0", req, exp_q.size());
      exp_q.delete();
    end
    total++;
    if (oe !== 1'b0 || dat !== 1'b1 || se0 !== 1'b0) begin
      bad++;
      $display("FAIL R7 line not idle after packet: got oe/dat/se0=%b%b%b expected 010", oe, dat, se0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    total++;
    if ({ready, oe, se0, dat} !== 4'b0001) begin
      bad++;
      $display("FAIL R1 reset outputs: got %b expected 0001", {ready, oe, se0, dat});
    end
    rst_ni = 1'b1;
    mon_on = 1'b1;
    // R2 valid held high from inside the guard window
    cur_req = "R2";
    tx_valid = 1'b1;
    tx_data  = 8'h55;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      total++;
      if (ready !== 1'b0 || oe !== 1'b0) begin
        bad++;
        $display("FAIL R2 guard ignored: got ready/oe=%b%b expected 00", ready, oe);
      end
    end
    tx_valid = 1'b0;
    repeat (10) @(negedge clk);
    total++;
    if ({ready, oe, se0, dat} !== 4'b0001) begin
      bad++;
      $display("FAIL R1 idle outputs: got %b expected 0001", {ready, oe, se0, dat});
    end

    send('{8'hA5, 8'h3C}, 2'd0, 2'd0, "R3 R6");
    send('{8'h01, 8'h02, 8'h80, 8'h7F, 8'hC3, 8'h10}, 2'd0, 2'd0, "R4");
    send('{8'hFF, 8'hFF, 8'h01}, 2'd0, 2'd0, "R5 boundary");
    send('{8'hFC}, 2'd0, 2'd0, "R5 tail");
    send('{}, 2'd0, 2'd0, "R7");
    send('{8'hFF, 8'hFF}, 2'd2, 2'd2, "R9");
    send('{8'hFF, 8'h7E}, 2'd3, 2'd3, "R10");
    send('{8'h12, 8'h34}, 2'd1, 2'd1, "R8");
    send('{8'hFF, 8'hFF}, 2'd0, 2'd2, "R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule